// File: doc/BRIEF.md
# Set-Associative Address Translation Lookup

This block translates a 32-bit virtual address into a physical page address for a software-managed translation cache. The cache is split into ways. Each way holds one entry per set. A lookup uses the low bits of the virtual page number to pick a set, then compares every way at that set in the same cycle. A registered result follows one clock after the request. The result carries a hit flag, the physical page address, the read, write and execute permissions, and the access type of the request, which passes through unchanged. A later pipeline stage can then compare the access type against the permissions.

Software fills entries through a separate maintenance port that names the way and set to write. A miss is only reported. Refilling, walking page tables and raising faults are left to the surrounding logic. An entry matches when its page number agrees with the lookup and the entry is either marked global or carries the current process ID. The current process ID is taken from a field of a control word.

Top module: `tlb_lookup_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is cleared to zero. Every stored tag word and data word is also cleared to zero.
- R2: A maintenance write with `mnt_we`=1 stores `mnt_tag` and `mnt_data` at way `mnt_way`, set `mnt_set`. The stored entry is visible to lookups from the next cycle onward. A lookup in the same cycle as the write sees the old contents.
- R3: The set searched is the low log2(ENTRIES/WAYS) bits of the virtual page number, where the page number is `req_vaddr[31:12]`. An entry stored at any other set never matches.
- R4: An entry matches when tag bits 31:12 equal `req_vaddr[31:12]` and one of the following holds:
  - tag bit 11 (global) is 1, or
  - tag bits PID_BITS-1:0 equal `ctl_misc[4 +: PID_BITS]`.
  
  Tag bit 10 (valid) and the bits of `ctl_misc` outside that field have no effect.
- R5: On a hit, `rsp_paddr` is data bits 19:0 shifted left by 12. `rsp_rd` is data bit 22, `rsp_wr` is data bit 21, and `rsp_ex` is data bit 20.
- R6: When several ways match, the way with the lowest index supplies the result.
- R7: On a miss, `rsp_hit`, `rsp_paddr`, `rsp_rd`, `rsp_wr` and `rsp_ex` are all zero.
- R8: `rsp_done` is high for exactly the one cycle after each cycle with `req_valid`=1. The result outputs are updated at that same edge.
- R9: `rsp_kind` takes the `req_kind` of the request: 0 means read, 1 means write, 2 means fetch.
- R10: In cycles without `req_valid`, the result outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| ctl_misc | input | 32 | Control word; current process ID at bits 4 upward |
| mnt_we | input | 1 | Maintenance write strobe |
| mnt_way | input | WAY_W | Way written by maintenance |
| mnt_set | input | SET_W | Set written by maintenance |
| mnt_tag | input | 32 | Tag word: page number 31:12, global 11, valid 10, PID low bits |
| mnt_data | input | 32 | Data word: R 22, W 21, X 20, frame number 19:0 |
| rsp_done | output | 1 | Result valid pulse |
| rsp_hit | output | 1 | Translation found |
| rsp_paddr | output | 32 | Physical page address |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_ex | output | 1 | Execute permitted |
| rsp_kind | output | 2 | Access type of the request |

## Verification
The hardest case to reach from the ports is two ways matching the same page at one set. This never arises from normal refills. The bench builds it on purpose: it writes an identical tag into way 0 and way 3 with different frame numbers. It then overwrites way 0 with another page number to show that way 3 takes over. A second awkward case is a maintenance write in the same cycle as a lookup of the same entry. The bench drives both strobes on one edge and expects a miss, followed by a hit on the next lookup.

// File: rtl/tlb_pkg.sv
// Shared constants for the translation lookup: page size and the bit
// positions of the tag and data words. Assumes 32-bit addresses.
package tlb_pkg;
    localparam int PAGE_SHIFT    = 12;
    localparam int VPN_W         = 32 - PAGE_SHIFT;
    localparam int PFN_W         = 20;
    localparam int TAG_GLOBAL    = 11;
    localparam int TAG_VALID     = 10;
    localparam int DATA_X        = 20;
    localparam int DATA_W        = 21;
    localparam int DATA_R        = 22;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } access_e;
endpackage

// File: rtl/tlb_way_bank.sv
// One way of the translation cache: a register array of tag and data
// words, written by set, read combinationally at the lookup set, and
// compared against the lookup page number and process ID.
// Assumes SETS >= 2 and PID_BITS <= 8.
module tlb_way_bank
    import tlb_pkg::*;
#(
    parameter int SETS     = 16,
    parameter int PID_BITS = 6,
    localparam int SET_W   = $clog2(SETS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SET_W-1:0]     wr_set,
    input  logic [31:0]          wr_tag,
    input  logic [31:0]          wr_data,
    input  logic [SET_W-1:0]     rd_set,
    input  logic [VPN_W-1:0]     look_vpn,
    input  logic [PID_BITS-1:0]  look_pid,
    output logic                 match,
    output logic [31:0]          rd_data
);
    logic [31:0] tag_q  [SETS];
    logic [31:0] data_q [SETS];
    logic [31:0] cur_tag;

    // Storage update: clear on reset, otherwise write the addressed set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                tag_q[s]  <= '0;
                data_q[s] <= '0;
            end
        end else if (wr_en) begin
            tag_q[wr_set]  <= wr_tag;
            data_q[wr_set] <= wr_data;
        end
    end

    // Read the entry at the lookup set and decide whether it matches.
    always_comb begin
        cur_tag = tag_q[rd_set];
        rd_data = data_q[rd_set];
        match   = (cur_tag[31:PAGE_SHIFT] == look_vpn) &&
                  (cur_tag[TAG_GLOBAL] || (cur_tag[PID_BITS-1:0] == look_pid));
    end

    logic unused_bank;
    assign unused_bank = ^{cur_tag[TAG_VALID:PID_BITS]};
endmodule

// File: rtl/tlb_first_hit.sv
// Priority selector: of all matching ways, picks the data word of the
// lowest-numbered one and flags whether any way matched.
module tlb_first_hit #(
    parameter int WAYS = 4
) (
    input  logic [WAYS-1:0]    hits,
    input  logic [WAYS*32-1:0] data_flat,
    output logic               any_hit,
    output logic [31:0]        sel_data
);
    // Scan from the highest way down so the lowest match is taken last.
    always_comb begin
        any_hit  = 1'b0;
        sel_data = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hits[w]) begin
                any_hit  = 1'b1;
                sel_data = data_flat[w*32 +: 32];
            end
        end
    end
endmodule

// File: rtl/tlb_lookup_unit.sv
// Top of the set-associative translation lookup. One bank per way is
// searched at the set chosen by the low page-number bits. The first
// matching way supplies frame number and permissions, which are
// registered one cycle after a request together with a done pulse.
// Assumes WAYS and ENTRIES are powers of two, ENTRIES/WAYS >= 2 and
// PID_BITS <= 8.
module tlb_lookup_unit
    import tlb_pkg::*;
#(
    parameter int WAYS     = 4,
    parameter int ENTRIES  = 64,
    parameter int PID_BITS = 6,
    localparam int SETS    = ENTRIES / WAYS,
    localparam int SET_W   = $clog2(SETS),
    localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [31:0]      req_vaddr,
    input  logic [1:0]       req_kind,
    input  logic [31:0]      ctl_misc,
    input  logic             mnt_we,
    input  logic [WAY_W-1:0] mnt_way,
    input  logic [SET_W-1:0] mnt_set,
    input  logic [31:0]      mnt_tag,
    input  logic [31:0]      mnt_data,
    output logic             rsp_done,
    output logic             rsp_hit,
    output logic [31:0]      rsp_paddr,
    output logic             rsp_rd,
    output logic             rsp_wr,
    output logic             rsp_ex,
    output logic [1:0]       rsp_kind
);
    logic [VPN_W-1:0]    look_vpn;
    logic [SET_W-1:0]    look_set;
    logic [PID_BITS-1:0] look_pid;
    logic [WAYS-1:0]     way_hit;
    logic [WAYS*32-1:0]  way_data;
    logic                any_hit;
    logic [31:0]         sel_data;

    assign look_vpn = req_vaddr[31:PAGE_SHIFT];
    assign look_set = look_vpn[SET_W-1:0];
    assign look_pid = ctl_misc[4 +: PID_BITS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tlb_way_bank #(
            .SETS     (SETS),
            .PID_BITS (PID_BITS)
        ) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (mnt_we && (mnt_way == WAY_W'(w))),
            .wr_set   (mnt_set),
            .wr_tag   (mnt_tag),
            .wr_data  (mnt_data),
            .rd_set   (look_set),
            .look_vpn (look_vpn),
            .look_pid (look_pid),
            .match    (way_hit[w]),
            .rd_data  (way_data[w*32 +: 32])
        );
    end

    tlb_first_hit #(.WAYS(WAYS)) pick_i (
        .hits      (way_hit),
        .data_flat (way_data),
        .any_hit   (any_hit),
        .sel_data  (sel_data)
    );

    // Result register: capture translation on a request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_paddr <= '0;
            rsp_rd    <= 1'b0;
            rsp_wr    <= 1'b0;
            rsp_ex    <= 1'b0;
            rsp_kind  <= '0;
        end else begin
            rsp_done <= req_valid;
            if (req_valid) begin
                rsp_hit   <= any_hit;
                rsp_paddr <= any_hit ? {sel_data[PFN_W-1:0], {PAGE_SHIFT{1'b0}}} : '0;
                rsp_rd    <= any_hit && sel_data[DATA_R];
                rsp_wr    <= any_hit && sel_data[DATA_W];
                rsp_ex    <= any_hit && sel_data[DATA_X];
                rsp_kind  <= req_kind;
            end
        end
    end

    logic unused_top;
    assign unused_top = ^{ctl_misc[31:4+PID_BITS], ctl_misc[3:0],
                          req_vaddr[PAGE_SHIFT-1:0], sel_data[31:DATA_R+1]};
endmodule

// File: rtl/tlb_lookup_chk.sv
// Protocol checks on the lookup unit's ports, attached by bind.
module tlb_lookup_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_kind,
    input logic        rsp_done,
    input logic        rsp_hit,
    input logic [31:0] rsp_paddr,
    input logic        rsp_rd,
    input logic        rsp_wr,
    input logic        rsp_ex,
    input logic [1:0]  rsp_kind
);
    p_done_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_done);

    p_no_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_done);

    p_kind_carried_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_kind == $past(req_kind)));

    p_miss_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !rsp_hit) |-> (rsp_paddr == 32'd0 && !rsp_rd && !rsp_wr && !rsp_ex));

    p_page_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_paddr[11:0] == 12'd0);

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_hit) && $stable(rsp_paddr) && $stable(rsp_kind)));
endmodule

bind tlb_lookup_unit tlb_lookup_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .rsp_done  (rsp_done),
    .rsp_hit   (rsp_hit),
    .rsp_paddr (rsp_paddr),
    .rsp_rd    (rsp_rd),
    .rsp_wr    (rsp_wr),
    .rsp_ex    (rsp_ex),
    .rsp_kind  (rsp_kind)
);

// File: tb/tlb_lookup_unit_tb_top.sv
module tlb_lookup_unit_tb_top;
    localparam int WAYS = 4, ENTRIES = 64, PID_BITS = 6;
    localparam int SET_W = 4, WAY_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [31:0]      req_vaddr = '0;
    logic [1:0]       req_kind = '0;
    logic [31:0]      ctl_misc = '0;
    logic             mnt_we = 1'b0;
    logic [WAY_W-1:0] mnt_way = '0;
    logic [SET_W-1:0] mnt_set = '0;
    logic [31:0]      mnt_tag = '0;
    logic [31:0]      mnt_data = '0;
    logic             rsp_done, rsp_hit, rsp_rd, rsp_wr, rsp_ex;
    logic [31:0]      rsp_paddr;
    logic [1:0]       rsp_kind;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tlb_lookup_unit #(.WAYS(WAYS), .ENTRIES(ENTRIES), .PID_BITS(PID_BITS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .ctl_misc(ctl_misc), .mnt_we(mnt_we), .mnt_way(mnt_way),
        .mnt_set(mnt_set), .mnt_tag(mnt_tag), .mnt_data(mnt_data),
        .rsp_done(rsp_done), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
        .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex), .rsp_kind(rsp_kind)
    );

    function automatic logic [31:0] mk_tag(logic [19:0] vpn, logic g, logic v, logic [5:0] pid);
        return {vpn, g, v, 4'b0, pid};
    endfunction

    function automatic logic [31:0] mk_data(logic r, logic w, logic x, logic [19:0] pfn);
        return {9'b0, r, w, x, pfn};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_entry(input int way, input int set, input logic [31:0] tag, input logic [31:0] data);
        @(negedge clk);
        mnt_we = 1'b1; mnt_way = WAY_W'(way); mnt_set = SET_W'(set);
        mnt_tag = tag; mnt_data = data;
        @(negedge clk);
        mnt_we = 1'b0;
    endtask

    // Issue one lookup; on return the registered result is on the outputs.
    task automatic lookup(input logic [31:0] va, input logic [1:0] kind, input logic [31:0] misc);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind; ctl_misc = misc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_result(input string req, input logic hit, input logic [31:0] pa,
                                 input logic r, input logic w, input logic x);
        check(rsp_done == 1'b1, req, {31'b0, rsp_done}, 32'd1);
        check(rsp_hit == hit, req, {31'b0, rsp_hit}, {31'b0, hit});
        check(rsp_paddr == pa, req, rsp_paddr, pa);
        check({rsp_rd, rsp_wr, rsp_ex} == {r, w, x}, req,
              {29'b0, rsp_rd, rsp_wr, rsp_ex}, {29'b0, r, w, x});
    endtask

    task automatic t_reset();
        // R1: outputs cleared
        check({rsp_done, rsp_hit, rsp_rd, rsp_wr, rsp_ex} == 5'b0, "R1",
              {27'b0, rsp_done, rsp_hit, rsp_rd, rsp_wr, rsp_ex}, 32'd0);
        check(rsp_paddr == 32'd0 && rsp_kind == 2'd0, "R1", rsp_paddr, 32'd0);
    endtask

    task automatic t_basic_hit();
        write_entry(1, 3, mk_tag(20'h12343, 1'b0, 1'b1, 6'd5), mk_data(1, 1, 0, 20'hABCDE));
        lookup(32'h1234_3567, 2'd1, 32'd5 << 4);
        expect_result("R5", 1'b1, 32'hABCD_E000, 1'b1, 1'b1, 1'b0);
        check(rsp_kind == 2'd1, "R9", {30'b0, rsp_kind}, 32'd1);
    endtask

    task automatic t_pid_match();
        lookup(32'h1234_3000, 2'd0, 32'd6 << 4);
        expect_result("R4 pid mismatch", 1'b0, 32'd0, 1'b0, 1'b0, 1'b0);
        lookup(32'h1234_3000, 2'd2, (32'd5 << 4) | (32'd1 << 10) | 32'hF);
        expect_result("R4 bits outside pid field", 1'b1, 32'hABCD_E000, 1'b1, 1'b1, 1'b0);
        check(rsp_kind == 2'd2, "R9", {30'b0, rsp_kind}, 32'd2);
    endtask

    task automatic t_global();
        // global bit set, valid bit clear: still a hit (R4)
        write_entry(2, 7, mk_tag(20'h00047, 1'b1, 1'b0, 6'd9), mk_data(0, 1, 1, 20'h00ABC));
        lookup(32'h0004_7FFF, 2'd2, 32'd0);
        expect_result("R4 global", 1'b1, 32'h00AB_C000, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_wrong_set();
        write_entry(1, 1, mk_tag(20'h00050, 1'b0, 1'b1, 6'd3), mk_data(1, 0, 0, 20'h77777));
        lookup(32'h0005_0123, 2'd0, 32'd3 << 4);
        expect_result("R3", 1'b0, 32'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_priority();
        write_entry(3, 9, mk_tag(20'h55559, 1'b0, 1'b1, 6'd2), mk_data(1, 0, 0, 20'h33333));
        write_entry(0, 9, mk_tag(20'h55559, 1'b0, 1'b1, 6'd2), mk_data(0, 0, 1, 20'h11111));
        lookup(32'h5555_9000, 2'd2, 32'd2 << 4);
        expect_result("R6 lowest way", 1'b1, 32'h1111_1000, 1'b0, 1'b0, 1'b1);
        write_entry(0, 9, mk_tag(20'h66669, 1'b0, 1'b1, 6'd2), mk_data(0, 0, 1, 20'h11111));
        lookup(32'h5555_9000, 2'd0, 32'd2 << 4);
        expect_result("R6 next way", 1'b1, 32'h3333_3000, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        mnt_we = 1'b1; mnt_way = 2'd1; mnt_set = 4'd12;
        mnt_tag = mk_tag(20'h0000C, 1'b0, 1'b1, 6'd1); mnt_data = mk_data(1, 1, 1, 20'h0C0C0);
        req_valid = 1'b1; req_vaddr = 32'h0000_C000; req_kind = 2'd0; ctl_misc = 32'd1 << 4;
        @(negedge clk);
        mnt_we = 1'b0; req_valid = 1'b0;
        expect_result("R2 same cycle old", 1'b0, 32'd0, 1'b0, 1'b0, 1'b0);
        lookup(32'h0000_C000, 2'd0, 32'd1 << 4);
        expect_result("R2 written", 1'b1, 32'h0C0C_0000, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic t_hold();
        @(negedge clk);
        check(rsp_done == 1'b0, "R8 single pulse", {31'b0, rsp_done}, 32'd0);
        check(rsp_hit == 1'b1 && rsp_paddr == 32'h0C0C_0000, "R10", rsp_paddr, 32'h0C0C_0000);
        req_vaddr = 32'h1234_3000;
        @(negedge clk);
        check(rsp_paddr == 32'h0C0C_0000 && rsp_kind == 2'd0, "R10", rsp_paddr, 32'h0C0C_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic_hit();
        t_pid_match();
        t_global();
        t_wrong_set();
        t_priority();
        t_same_cycle();
        t_hold();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule